// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block sits inside a memory controller and keeps track of whether each SDRAM bank has a row open or is idle. Requests come in on a valid/ready port. Each request carries an operation code and a bank number. The block checks each request against the state of the bank. A legal request becomes a registered command that the pin sequencer drives out. An illegal request becomes a one-cycle error pulse, and no command is issued for it.

A precharge can close one bank or every bank at once. The scope of a precharge is carried on the address-10 line of the command: it is high for every bank and low for one bank. After a precharge, each affected bank runs its own recovery counter. An activate to a bank that is still recovering is held off by back-pressure.

Back-pressure rule: `req_ready` depends only on the request payload. It falls only when the presented request is an activate to a bank whose recovery has not yet ended. While `req_valid` is high and `req_ready` is low, the requester must hold the op and bank stable. A request is consumed on any edge where `req_valid` and `req_ready` are both high.

The 4-bit open-bank vector is a plain status output for the power-down logic.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, every bank reads idle (`bank_open` = 0), `cmd_valid` and `err_pulse` are low, and an activate to any bank is accepted at once.
- R2: An accepted activate (op 1) to an idle bank produces a command in the next cycle: `cmd_valid`=1, `cmd_op`=1, `cmd_ba`=bank, `cmd_a10`=0. The same edge sets that bank's `bank_open` bit.
- R3: An accepted read (op 2) or write (op 3) to an open bank produces a command of the same op in the next cycle, with `cmd_ba`=bank and `cmd_a10`=0. `bank_open` is unchanged.
- R4: A read or write to an idle bank produces `err_pulse`=1 for one cycle and no command. `bank_open` is unchanged.
- R5: An activate to a bank that is already open produces `err_pulse`=1 for one cycle and no command. `bank_open` is unchanged.
- R6: A single-bank precharge (op 4) is always issued, even to an idle bank: `cmd_op`=4, `cmd_a10`=0, `cmd_ba`=bank. It clears only that bank's `bank_open` bit.
- R7: An all-bank precharge (op 5) is issued with `cmd_op`=5 and `cmd_a10`=1. `cmd_ba` is driven to 0 whatever bank was requested. It clears every `bank_open` bit.
- R8: Suppose a precharge that covers bank b is accepted on edge k. An activate to bank b is then not accepted before edge k+TRP_CYCLES. So a request held from the next cycle on sees `req_ready` low for TRP_CYCLES-1 cycles. A later precharge restarts the wait.
- R9: `req_ready` is low only when the presented op is an activate to a bank that is still recovering. Other banks and other ops are never stalled.
- R10: Op 0 with `req_valid` high is consumed with no command and no error. Op 6 and op 7 are consumed with an error pulse and no command.
- R11: Each consumed request gives at most one response, either a command or an error pulse, never both. When no command is issued, `cmd_op`, `cmd_a10` and `cmd_ba` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be consumed this cycle |
| req_op | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all |
| req_bank | input | 2 | Target bank |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | Issued command, same codes as `req_op` |
| cmd_a10 | output | 1 | Address-10 value: high for all-bank precharge |
| cmd_ba | output | 2 | Bank address of the command |
| err_pulse | output | 1 | One-cycle pulse for a refused request |
| bank_open | output | 4 | Per-bank open-row flag, bit i for bank i |

## Verification
Directed sequences come first. They exercise each legality case in turn: read to an open bank versus an idle bank, activate to an open bank, precharge to an idle bank, and an all-bank precharge with a non-zero bank field. Together these separate the issue path from the error path and show whether the bank field is masked. A held activate right after a precharge counts the stalled cycles, which exposes an off-by-one in the recovery counter. A long run with a fixed seed then mixes ops, weighted toward activates and precharges, so that activates often land inside recovery windows left by one-bank and all-bank precharges. That run checks readiness, command fields and the open vector every cycle against a model in the bench.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_NONE    = 3'd0;
  localparam logic [OP_W-1:0] OP_ACT     = 3'd1;
  localparam logic [OP_W-1:0] OP_RD      = 3'd2;
  localparam logic [OP_W-1:0] OP_WR      = 3'd3;
  localparam logic [OP_W-1:0] OP_PRE_ONE = 3'd4;
  localparam logic [OP_W-1:0] OP_PRE_ALL = 3'd5;

  typedef enum logic [1:0] {
    VERDICT_DROP  = 2'd0,
    VERDICT_ISSUE = 2'd1,
    VERDICT_FAULT = 2'd2
  } verdict_e;
endpackage

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot #(
  parameter int TRP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic pre_hit,
  output logic is_open,
  output logic recovering
);
  localparam int TW = (TRP_CYCLES > 1) ? $clog2(TRP_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(TRP_CYCLES - 1);

  logic          open_q;
  logic [TW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wait_q <= '0;
    end else if (pre_hit) begin
      open_q <= 1'b0;
      wait_q <= RELOAD;
    end else begin
      if (act_hit) open_q <= 1'b1;
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
    end
  end

  assign is_open    = open_q;
  assign recovering = (wait_q != '0);

  // R8
  act_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |-> !recovering);
  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= RELOAD);
  // R2
  open_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && !pre_hit) |=> is_open);
  // R6
  closed_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> !is_open);
endmodule

// File: rtl/sbt_req_check.sv
module sbt_req_check
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 fire,
  input  logic [OP_W-1:0]      op,
  input  logic [BA_W-1:0]      bank,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] recov_vec,
  output logic                 stall,
  output logic                 issue,
  output logic                 fault,
  output logic [NUM_BANKS-1:0] act_hits,
  output logic [NUM_BANKS-1:0] pre_hits
);
  verdict_e verdict;

  assign stall = (op == OP_ACT) && recov_vec[bank];

  always_comb begin
    verdict = VERDICT_DROP;
    case (op)
      OP_NONE:                verdict = VERDICT_DROP;
      OP_ACT:                 verdict = open_vec[bank] ? VERDICT_FAULT : VERDICT_ISSUE;
      OP_RD, OP_WR:           verdict = open_vec[bank] ? VERDICT_ISSUE : VERDICT_FAULT;
      OP_PRE_ONE, OP_PRE_ALL: verdict = VERDICT_ISSUE;
      default:                verdict = VERDICT_FAULT;
    endcase
  end

  assign issue = fire && (verdict == VERDICT_ISSUE);
  assign fault = fire && (verdict == VERDICT_FAULT);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
    assign act_hits[i] = issue && (op == OP_ACT) && (bank == BA_W'(i));
    assign pre_hits[i] = issue && ((op == OP_PRE_ALL) ||
                                   ((op == OP_PRE_ONE) && (bank == BA_W'(i))));
  end
endmodule

// File: rtl/sbt_cmd_reg.sv
module sbt_cmd_reg
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            fault,
  input  logic [OP_W-1:0] op,
  input  logic [BA_W-1:0] bank,
  output logic            cmd_valid,
  output logic [OP_W-1:0] cmd_op,
  output logic            cmd_a10,
  output logic [BA_W-1:0] cmd_ba,
  output logic            err_pulse
);
  logic all_scope;
  assign all_scope = (op == OP_PRE_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_a10   <= 1'b0;
      cmd_ba    <= '0;
      err_pulse <= 1'b0;
    end else begin
      cmd_valid <= issue;
      err_pulse <= fault;
      cmd_op    <= issue ? op : OP_NONE;
      cmd_a10   <= issue && all_scope;
      cmd_ba    <= (issue && !all_scope) ? bank : '0;
    end
  end

  // R11
  single_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && err_pulse));
  // R7
  a10_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a10 |-> (cmd_op == OP_PRE_ALL) && (cmd_ba == '0));
  // R11
  idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_op == OP_NONE) && !cmd_a10);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int TRP_CYCLES = 3,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic [BA_W-1:0]      req_bank,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_op,
  output logic                 cmd_a10,
  output logic [BA_W-1:0]      cmd_ba,
  output logic                 err_pulse,
  output logic [NUM_BANKS-1:0] bank_open
);
  logic                 stall, fire, issue, fault;
  logic [NUM_BANKS-1:0] open_vec, recov_vec, act_hits, pre_hits;

  assign req_ready = !stall;
  assign fire      = req_valid && req_ready;

  sbt_req_check #(.NUM_BANKS(NUM_BANKS)) u_check (
    .fire      (fire),
    .op        (req_op),
    .bank      (req_bank),
    .open_vec  (open_vec),
    .recov_vec (recov_vec),
    .stall     (stall),
    .issue     (issue),
    .fault     (fault),
    .act_hits  (act_hits),
    .pre_hits  (pre_hits)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    sbt_bank_slot #(.TRP_CYCLES(TRP_CYCLES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_hit    (act_hits[i]),
      .pre_hit    (pre_hits[i]),
      .is_open    (open_vec[i]),
      .recovering (recov_vec[i])
    );
  end

  sbt_cmd_reg #(.NUM_BANKS(NUM_BANKS)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .fault     (fault),
    .op        (req_op),
    .bank      (req_bank),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_a10   (cmd_a10),
    .cmd_ba    (cmd_ba),
    .err_pulse (err_pulse)
  );

  assign bank_open = open_vec;

  // R9
  stall_only_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (req_op == OP_ACT));
  // R4
  idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_op == OP_RD || req_op == OP_WR) && !bank_open[req_bank])
    |=> err_pulse && !cmd_valid);
  // R7
  all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_op == OP_PRE_ALL) |=> (bank_open == '0) && cmd_a10);
endmodule

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;
  localparam int NB  = 4;
  localparam int TRP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic       cmd_valid, cmd_a10, err_pulse;
  logic [2:0] cmd_op;
  logic [1:0] cmd_ba;
  logic [3:0] bank_open;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [3:0] m_open;
  int         m_tmr [NB];
  logic       e_cv, e_a10, e_err;
  logic [2:0] e_op;
  logic [1:0] e_ba;
  logic       rdy_seen;

  always #2.5 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(NB), .TRP_CYCLES(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_a10(cmd_a10), .cmd_ba(cmd_ba),
    .err_pulse(err_pulse), .bank_open(bank_open)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic is_open);
    case (op)
      3'd1: return is_open ? "R5" : "R2";
      3'd2, 3'd3: return is_open ? "R3" : "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [1:0] b);
    logic exp_rdy, fire;
    logic [3:0] reload;
    string tg;
    req_valid = v; req_op = op; req_bank = b;
    #1;
    exp_rdy = !(op == 3'd1 && m_tmr[b] != 0);
    rdy_seen = req_ready;
    chk(exp_rdy ? "R9" : "R8", "req_ready", req_ready, exp_rdy);
    fire = v && exp_rdy;
    tg = fire ? tag_of(op, m_open[b]) : "R8";
    e_cv = 0; e_op = 0; e_a10 = 0; e_ba = 0; e_err = 0; reload = 4'b0;
    if (fire) begin
      case (op)
        3'd0: ;
        3'd1: if (m_open[b]) e_err = 1;
              else begin e_cv = 1; e_op = op; e_ba = b; m_open[b] = 1'b1; end
        3'd2, 3'd3: if (m_open[b]) begin e_cv = 1; e_op = op; e_ba = b; end
                    else e_err = 1;
        3'd4: begin e_cv = 1; e_op = op; e_ba = b; m_open[b] = 1'b0; reload[b] = 1'b1; end
        3'd5: begin e_cv = 1; e_op = op; e_a10 = 1; e_ba = 0; m_open = 4'b0; reload = 4'hF; end
        default: e_err = 1;
      endcase
    end
    for (int i = 0; i < NB; i++) begin
      if (reload[i]) m_tmr[i] = TRP - 1;
      else if (m_tmr[i] > 0) m_tmr[i] = m_tmr[i] - 1;
    end
    @(posedge clk); @(negedge clk);
    chk(tg, "cmd_valid", cmd_valid, e_cv);
    chk(tg, "cmd_op", cmd_op, e_op);
    chk(tg, "cmd_a10", cmd_a10, e_a10);
    chk(tg, "cmd_ba", cmd_ba, e_ba);
    chk(tg, "err_pulse", err_pulse, e_err);
    chk(tg, "bank_open", bank_open, m_open);
    if (cmd_valid && err_pulse) chk("R11", "cmd_and_err", 1, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int stalls;
    logic hold;
    logic [2:0] rop;
    logic [1:0] rb;
    logic rv;
    int r;
    m_open = 4'b0;
    for (int i = 0; i < NB; i++) m_tmr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "err_pulse", err_pulse, 0);
    chk("R1", "bank_open", bank_open, 0);
    req_op = 3'd1; req_bank = 2'd3; #1;
    chk("R1", "req_ready", req_ready, 1);

    // directed cases
    step(1, 3'd1, 2'd0);  // R2 activate idle bank
    step(1, 3'd2, 2'd0);  // R3 read open bank
    step(1, 3'd3, 2'd0);  // R3 write open bank
    step(1, 3'd3, 2'd1);  // R4 write idle bank
    step(1, 3'd1, 2'd0);  // R5 activate open bank
    step(1, 3'd4, 2'd1);  // R6 precharge idle bank
    step(1, 3'd1, 2'd2);  // R2 (bank 1 still recovering)
    step(1, 3'd5, 2'd3);  // R7 all-bank with non-zero bank field
    step(1, 3'd0, 2'd2);  // R10 no-op
    step(1, 3'd6, 2'd2);  // R10 reserved
    step(1, 3'd7, 2'd1);  // R10 reserved
    // R8 stall count for activate after precharge
    step(1, 3'd4, 2'd2);
    stalls = 0;
    for (int k = 0; k < 10; k++) begin
      step(1, 3'd1, 2'd2);
      if (rdy_seen) break;
      stalls++;
    end
    chk("R8", "stall_cycles", stalls, TRP - 1);
    step(0, 3'd1, 2'd3);  // valid low: nothing

    // constrained random
    void'($urandom(32'd2024));
    hold = 0; rop = 0; rb = 0; rv = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!hold) begin
        r  = $urandom_range(0, 15);
        rb = 2'($urandom_range(0, 3));
        rv = 1;
        if (r <= 4) rop = 3'd1;
        else if (r <= 7) rop = 3'd2;
        else if (r <= 9) rop = 3'd3;
        else if (r <= 11) rop = 3'd4;
        else if (r == 12) rop = 3'd5;
        else if (r == 13) rop = 3'd0;
        else if (r == 14) rop = 3'(6 + $urandom_range(0, 1));
        else begin rop = 3'd1; rv = 0; end
      end
      step(rv, rop, rb);
      hold = rv && !rdy_seen;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule